// File: doc/BRIEF.md
# Mode-Selectable Clock Divider with Bypass

This block turns a fast oscillator clock into a set of matched output clocks. A 3-bit select code picks one of four even divide ratios. The block drives several identical full-rate outputs and a dedicated feedback copy, all from the same register, so every copy changes on the same oscillator edge. A half-rate output toggles on each rising edge of the full-rate clock. The full-rate outputs have an exact 50/50 duty cycle because each ratio is even.

One select code is a test bypass. In that mode the reference clock input drives the full-rate outputs directly, so surrounding logic can be stepped by hand. The half-rate output then toggles on each rising edge of the reference clock.

Codes that select no ratio force every output low. The select inputs pass through a two-stage synchronizer. Any change of the synchronized code restarts the divider from a clean low phase, so no runt pulse is produced.

Top module: `clk_mode_div`

## Requirements
- R1: Code 3'b111 divides by 12: the full-rate outputs are high for 6 and low for 6 oscillator cycles.
- R2: Code 3'b110 divides by 10 (5 high, 5 low), code 3'b100 by 8 (4/4), and code 3'b011 by 6 (3/3).
- R3: Every bit of `fast_o` equals `fb_o` at all times.
- R4: In divide modes, `half_o` toggles on each rising edge of the full-rate clock. The first full-rate rise after a restart sets it high.
- R5: With code 3'b101 applied, `fast_o` and `fb_o` follow `ref_clk_i` level for level.
- R6: With code 3'b101 applied, `half_o` toggles on each rising edge of `ref_clk_i`.
- R7: Codes 3'b000, 3'b001 and 3'b010 drive `fast_o`, `fb_o` and `half_o` low for as long as they are applied.
- R8: A new code reaches the decoder after two synchronizer stages. The third rising oscillator edge after the change clears the divider. The full-rate outputs then stay low for one half-period of the new ratio and rise on edge 3+H, where H is half the ratio.
- R9: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator clock that is divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Test clock routed to the outputs in bypass mode |
| sel_i | input | 3 | Mode select code, asynchronous to `osc_clk_i` |
| fast_o | output | NUM_FAST | Full-rate output copies |
| fb_o | output | 1 | Full-rate feedback copy |
| half_o | output | 1 | Half-rate output |

## Verification
Each divide code is entered from a reserved code, so the divider always restarts from a known state. The bench checks the exact edge of the first rise, which separates a correct restart-and-synchronize latency from an off-by-one count or a missing clear. Over two full-rate periods it checks the high and low run lengths, which tell the four ratios apart and expose a wrong terminal count or a skipped toggle. The half-rate phase is checked in the same window. A randomly ordered run of the codes, plus a direct jump from bypass into a divide mode, exercises restart from different previous modes. In bypass, an irregular reference waveform shows that the outputs follow the level and that the half-rate output counts only rising edges.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int MAX_HALF = 6;
  localparam int HALF_W   = $clog2(MAX_HALF + 1);

  typedef logic [2:0] sel_t;
  localparam sel_t SEL_BYPASS = 3'b101;

  // half-period in oscillator cycles; zero means no divide mode
  function automatic logic [HALF_W-1:0] half_period(sel_t s);
    case (s)
      3'b111:  return HALF_W'(6);
      3'b110:  return HALF_W'(5);
      3'b100:  return HALF_W'(4);
      3'b011:  return HALF_W'(3);
      default: return '0;
    endcase
  endfunction

  function automatic logic is_bypass(sel_t s);
    return s == SEL_BYPASS;
  endfunction
endpackage

// File: rtl/sel_sync.sv
module sel_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/div_core.sv
module div_core
  import clkdiv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  sel_t code_i,
  output logic full_o,
  output logic half_o,
  output logic bypass_o
);
  localparam int CNT_W = HALF_W;

  sel_t             code_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full_q, half_q;
  logic [HALF_W-1:0] hper;
  logic             changed, div_en, wrap;

  assign hper    = half_period(code_q);
  assign changed = (code_i != code_q);
  assign div_en  = (hper != '0);
  assign wrap    = (cnt_q == hper - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      half_q <= 1'b0;
    end else if (changed) begin
      // restart cleanly: no runt pulse on a mode switch
      code_q <= code_i;
      cnt_q  <= '0;
      full_q <= 1'b0;
      half_q <= 1'b0;
    end else if (!div_en) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      half_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      full_q <= ~full_q;
      if (!full_q) half_q <= ~half_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign full_o   = full_q;
  assign half_o   = half_q;
  assign bypass_o = is_bypass(code_q);

  p_restart_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed |=> (cnt_q == '0) && !full_q && !half_q);

  p_reserved_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!changed && !div_en) |=> !full_q && !half_q);

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_en |-> (cnt_q < CNT_W'(hper)));

  p_duty_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_en && !changed && !wrap) |=> $stable(full_q));

  p_half_on_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!changed && div_en && wrap && !full_q) |=> (half_q != $past(half_q)));
endmodule

// File: rtl/ref_half.sv
module ref_half (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic half_o
);
  logic half_q;

  // en_i is quasi-static: it changes only on a mode switch
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)   half_q <= 1'b0;
    else if (en_i) half_q <= ~half_q;
  end

  assign half_o = half_q;
endmodule

// File: rtl/clk_mode_div.sv
module clk_mode_div
  import clkdiv_pkg::*;
#(
  parameter int NUM_FAST    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                osc_clk_i,
  input  logic                rst_ni,
  input  logic                ref_clk_i,
  input  logic [2:0]          sel_i,
  output logic [NUM_FAST-1:0] fast_o,
  output logic                fb_o,
  output logic                half_o
);
  sel_t sel_s;
  logic full_div, half_div, half_ref, byp;
  logic full_mux;

  sel_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (osc_clk_i),
    .rst_ni(rst_ni),
    .d_i   (sel_i),
    .q_o   (sel_s)
  );

  div_core u_core (
    .clk_i   (osc_clk_i),
    .rst_ni  (rst_ni),
    .code_i  (sel_s),
    .full_o  (full_div),
    .half_o  (half_div),
    .bypass_o(byp)
  );

  ref_half u_ref_half (
    .ref_clk_i(ref_clk_i),
    .rst_ni   (rst_ni),
    .en_i     (byp),
    .half_o   (half_ref)
  );

  assign full_mux = byp ? ref_clk_i : full_div;

  for (genvar g = 0; g < NUM_FAST; g++) begin : g_fast
    assign fast_o[g] = full_mux;
  end
  assign fb_o   = full_mux;
  assign half_o = byp ? half_ref : half_div;
endmodule

// File: tb/clk_mode_div_test.sv
module clk_mode_div_test;
  localparam int T_CLK = 10;
  localparam int NF    = 9;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ref_clk = 1'b0;
  logic [2:0]    sel = 3'b111;
  logic [NF-1:0] fast;
  logic          fb, half;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #(T_CLK/2) clk = ~clk;

  clk_mode_div #(.NUM_FAST(NF), .SYNC_STAGES(2)) uut (
    .osc_clk_i(clk), .rst_ni(rst_ni), .ref_clk_i(ref_clk), .sel_i(sel),
    .fast_o(fast), .fb_o(fb), .half_o(half)
  );

  function automatic int exp_h(logic [2:0] c);
    case (c)
      3'b111: return 6;
      3'b110: return 5;
      3'b100: return 4;
      3'b011: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic reserved_phase(input logic [2:0] c);
    sel = c;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k >= 4) begin
        chk(fast == '0, "R7 fast", int'(fast), 0);
        chk(fb == 1'b0 && half == 1'b0, "R7 fb/half", int'({fb, half}), 0);
      end
    end
  endtask

  task automatic run_div(input logic [2:0] c);
    int h = exp_h(c);
    string tag = (c == 3'b111) ? "R1" : "R2";
    sel = c;
    for (int k = 1; k <= h + 3; k++) begin
      @(negedge clk);
      if (k == h + 2) chk(fb == 1'b0, "R8 low before first rise", fb, 0);
      if (k == h + 3) chk(fb == 1'b1, "R8 first rise", fb, 1);
    end
    chk(half == 1'b1, "R4 half at first rise", half, 1);
    for (int j = 1; j < 4 * h; j++) begin
      bit ef, eh;
      @(negedge clk);
      ef = ((j / h) % 2) == 0;
      eh = ((j / (2 * h)) % 2) == 0;
      chk(fb == ef, tag, fb, ef);
      chk(half == eh, "R4", half, eh);
      chk(fast == {NF{fb}}, "R3", int'(fast), int'({NF{fb}}));
    end
  endtask

  task automatic bypass_pulse(input int hi_ns, input int lo_ns);
    logic h0 = half;
    ref_clk = 1'b1;
    #1;
    chk(fast == {NF{1'b1}} && fb, "R5 high", int'(fast), int'({NF{1'b1}}));
    chk(half == ~h0, "R6 toggle", half, ~h0);
    #(hi_ns);
    chk(half == ~h0, "R6 stable", half, ~h0);
    ref_clk = 1'b0;
    #1;
    chk(fast == '0 && !fb, "R5 low", int'(fast), 0);
    chk(half == ~h0, "R6 no toggle on fall", half, ~h0);
    #(lo_ns);
  endtask

  initial begin
    int seed;
    logic [2:0] vcodes [4] = '{3'b111, 3'b110, 3'b100, 3'b011};
    seed = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    chk(fast == '0 && !fb && !half, "R9 reset", int'({fast, fb, half}), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < 4; i++) begin
      reserved_phase(3'b000);
      run_div(vcodes[i]);
    end
    for (int i = 0; i < 6; i++) begin
      reserved_phase(3'($urandom_range(0, 2)));
      run_div(vcodes[$urandom_range(0, 3)]);
    end

    sel = 3'b101;
    repeat (5) @(negedge clk);
    chk(fast == '0 && !fb, "R5 follows low ref", int'(fast), 0);
    for (int i = 0; i < 8; i++) bypass_pulse(2 + $urandom_range(0, 20), 2 + $urandom_range(0, 20));
    @(negedge clk);
    run_div(3'b110);

    reserved_phase(3'b010);
    reserved_phase(3'b001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(T_CLK * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule